// File: doc/BRIEF.md
# Protected Register Write Unlock

This block sits on a simple synchronous register bus. It keeps three 8-bit control registers safe from stray stores. A protected register changes only when the write to it comes straight after a write to a separate command register. That command write arms the unlock, and the value written with it does not matter. The arm lasts for exactly one bus write.

If a protected register is written at any other time, the write is dropped and a sticky protection-error flag is set. This covers a write with no arm at all, and a write that follows a command write but has some other write in between (an interrupt handler store, for example, or a DMA transfer). The error flag is bit 0 of a status register. Software clears it by writing 0 to that bit.

Reads need no sequence. A read returns the current value one cycle after it is requested.

Top module: `prot_reg_unlock`

## Requirements
- R1: A write to the command register (address 0x0) arms the unlock, whatever data it carries.
- R2: A write to a protected register (addresses 0x4, 0x5, 0x6) that is the first bus write after a command write stores its data. It does not touch the error flag.
- R3: A write to any other address between the command write and the protected write cancels the arm. The address may be the status register or an unmapped address. The protected write that follows is then dropped and the error flag is set.
- R4: A protected-register write made while not armed is dropped and sets the error flag (status bit 0).
- R5: Any bus write uses up the arm, so a single command write allows at most one protected write. A second protected write in a row is dropped and sets the error flag.
- R6: Reads of any address, including the command register, leave the arm state as it was.
- R7: The error flag stays set until a status write (address 0x1) has 0 in bit 0. Writing 1 to that bit does not change the flag, and a successful protected write does not clear it.
- R8: Readback data appears on rdata_o in the cycle after re_i is asserted. Status reads return {7'b0, error}. The command register and unmapped addresses read as 0x00.
- R9: Reset clears the arm and the error flag. It loads the protected registers with 0x00, 0x0F and 0xA5 (addresses 0x4, 0x5, 0x6).
- R10: A write to one protected register leaves the other two unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Byte write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 8 | Registered read data |

## Verification
The arm state is internal and cannot be read directly. A fault in it shows up only at the next protected write. If the arm is stuck high, an unsequenced write gets through, and a protected-register read taken one cycle later shows the new value. If the arm is stuck low or cleared too early, a valid sequence is refused, and the next status read shows the error bit set. A fault in the error flag shows up on the first status read after the event. The bench therefore follows every sequence with reads of the target register, the status register and the neighbouring registers.

// File: rtl/prot_reg_pkg.sv
package prot_reg_pkg;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int NPROT = 3;

  localparam logic [AW-1:0] CMD_ADDR  = 4'h0;
  localparam logic [AW-1:0] STAT_ADDR = 4'h1;
  localparam logic [AW-1:0] PROT_BASE = 4'h4;
  localparam int            PERR_BIT  = 0;

  localparam logic [NPROT-1:0][DW-1:0] PROT_RST = {8'hA5, 8'h0F, 8'h00};
endpackage

// File: rtl/prot_unlock_ctrl.sv
module prot_unlock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic is_cmd_i,
  input  logic is_prot_i,
  input  logic stat_wr_i,
  input  logic stat_bit_i,
  output logic armed_o,
  output logic perr_o
);
  logic armed_q, perr_q;
  logic perr_set, perr_clr;

  assign perr_set = we_i && is_prot_i && !armed_q;
  assign perr_clr = stat_wr_i && !stat_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      // every write consumes the arm; only a command write re-arms
      if (we_i) armed_q <= is_cmd_i;
      if (perr_set)      perr_q <= 1'b1;
      else if (perr_clr) perr_q <= 1'b0;
    end
  end

  assign armed_o = armed_q;
  assign perr_o  = perr_q;

  // R1
  cmd_arms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && is_cmd_i |=> armed_o);
  // R5
  arm_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !is_cmd_i |=> !armed_o);
  // R6
  read_keeps_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> armed_o == $past(armed_o));
  // R4
  unarmed_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && is_prot_i && !armed_o |=> perr_o);
  // R7
  perr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o && !(stat_wr_i && !stat_bit_i) |=> perr_o);
endmodule

// File: rtl/prot_reg_bank.sv
module prot_reg_bank #(
  parameter int NPROT = prot_reg_pkg::NPROT,
  parameter int DW    = prot_reg_pkg::DW,
  parameter logic [NPROT-1:0][DW-1:0] RST = prot_reg_pkg::PROT_RST
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPROT-1:0]           wr_en_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [NPROT-1:0][DW-1:0]   q_o
);
  for (genvar k = 0; k < NPROT; k++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= RST[k];
      else if (wr_en_i[k]) q <= wdata_i;
    end
    assign q_o[k] = q;

    // R3
    hold_when_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i[k] |=> $stable(q_o[k]));
    // R2
    store_when_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[k] |=> q_o[k] == $past(wdata_i));
  end

  // R10
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_i));
endmodule

// File: rtl/prot_readback.sv
module prot_readback #(
  parameter int AW    = prot_reg_pkg::AW,
  parameter int DW    = prot_reg_pkg::DW,
  parameter int NPROT = prot_reg_pkg::NPROT
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     re_i,
  input  logic [AW-1:0]            addr_i,
  input  logic                     perr_i,
  input  logic [NPROT-1:0][DW-1:0] q_i,
  output logic [DW-1:0]            rdata_o
);
  import prot_reg_pkg::*;

  logic [DW-1:0] rd_mux, rdata_q;

  always_comb begin
    rd_mux = '0;
    if (addr_i == STAT_ADDR) rd_mux[PERR_BIT] = perr_i;
    for (int k = 0; k < NPROT; k++) begin
      if (addr_i == PROT_BASE + AW'(k)) rd_mux = q_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R8
  cmd_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && addr_i == CMD_ADDR |=> rdata_o == '0);
  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/prot_reg_unlock.sv
module prot_reg_unlock
  import prot_reg_pkg::*;
#(
  parameter int AW    = prot_reg_pkg::AW,
  parameter int DW    = prot_reg_pkg::DW,
  parameter int NPROT = prot_reg_pkg::NPROT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o
);
  logic                     is_cmd, is_stat, is_prot;
  logic [NPROT-1:0]         prot_hit, prot_wr;
  logic                     armed, perr;
  logic [NPROT-1:0][DW-1:0] prot_q;

  assign is_cmd  = (addr_i == CMD_ADDR);
  assign is_stat = (addr_i == STAT_ADDR);

  for (genvar k = 0; k < NPROT; k++) begin : g_dec
    assign prot_hit[k] = (addr_i == PROT_BASE + AW'(k));
    assign prot_wr[k]  = we_i && prot_hit[k] && armed;
  end
  assign is_prot = |prot_hit;

  prot_unlock_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .is_cmd_i   (is_cmd),
    .is_prot_i  (is_prot),
    .stat_wr_i  (we_i && is_stat),
    .stat_bit_i (wdata_i[PERR_BIT]),
    .armed_o    (armed),
    .perr_o     (perr)
  );

  prot_reg_bank #(.NPROT(NPROT), .DW(DW)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (prot_wr),
    .wdata_i (wdata_i),
    .q_o     (prot_q)
  );

  prot_readback #(.AW(AW), .DW(DW), .NPROT(NPROT)) u_rb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (re_i),
    .addr_i  (addr_i),
    .perr_i  (perr),
    .q_i     (prot_q),
    .rdata_o (rdata_o)
  );

  // R2
  armed_write_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && is_prot && armed && !perr |=> !perr);
endmodule

// File: tb/prot_reg_unlock_bench.sv
module prot_reg_unlock_bench;
  localparam time CLK_P = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic       re_i = 1'b0;
  logic [7:0] rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  prot_reg_unlock u_prot_reg_unlock (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o)
  );

  // {req[3:0], we, re, addr[3:0], wdata[7:0], exp[7:0]}
  localparam int NV = 37;
  localparam logic [25:0] VEC [NV] = '{
    {4'd9, 1'b0,1'b1,4'h4,8'h00,8'h00}, // R9 reset value reg0
    {4'd9, 1'b0,1'b1,4'h5,8'h00,8'h0F}, // R9
    {4'd9, 1'b0,1'b1,4'h6,8'h00,8'hA5}, // R9
    {4'd9, 1'b0,1'b1,4'h1,8'h00,8'h00}, // R9 status clear
    {4'd1, 1'b1,1'b0,4'h0,8'h00,8'h00}, // R1 arm with 0x00
    {4'd2, 1'b1,1'b0,4'h4,8'h3C,8'h00}, // R2
    {4'd2, 1'b0,1'b1,4'h4,8'h00,8'h3C}, // R2
    {4'd10,1'b0,1'b1,4'h5,8'h00,8'h0F}, // R10
    {4'd2, 1'b0,1'b1,4'h1,8'h00,8'h00}, // R2 no error
    {4'd1, 1'b1,1'b0,4'h0,8'hFF,8'h00}, // R1 arm with 0xFF
    {4'd8, 1'b0,1'b1,4'h0,8'h00,8'h00}, // R8 cmd reads 0, R6
    {4'd6, 1'b0,1'b1,4'h1,8'h00,8'h00}, // R6
    {4'd6, 1'b1,1'b0,4'h5,8'h77,8'h00}, // R6 write after reads
    {4'd6, 1'b0,1'b1,4'h5,8'h00,8'h77}, // R6
    {4'd4, 1'b1,1'b0,4'h6,8'h11,8'h00}, // R4 unarmed
    {4'd4, 1'b0,1'b1,4'h6,8'h00,8'hA5}, // R4
    {4'd4, 1'b0,1'b1,4'h1,8'h00,8'h01}, // R4
    {4'd7, 1'b1,1'b0,4'h1,8'h01,8'h00}, // R7 write 1
    {4'd7, 1'b0,1'b1,4'h1,8'h00,8'h01}, // R7
    {4'd7, 1'b1,1'b0,4'h0,8'h00,8'h00}, // R7 arm
    {4'd7, 1'b1,1'b0,4'h6,8'h5A,8'h00}, // R7 good write
    {4'd7, 1'b0,1'b1,4'h1,8'h00,8'h01}, // R7 still set
    {4'd2, 1'b0,1'b1,4'h6,8'h00,8'h5A}, // R2
    {4'd7, 1'b1,1'b0,4'h1,8'h00,8'h00}, // R7 clear
    {4'd7, 1'b0,1'b1,4'h1,8'h00,8'h00}, // R7
    {4'd3, 1'b1,1'b0,4'h0,8'h00,8'h00}, // R3 arm
    {4'd3, 1'b1,1'b0,4'hF,8'h99,8'h00}, // R3 intervening write
    {4'd3, 1'b1,1'b0,4'h4,8'hEE,8'h00}, // R3
    {4'd3, 1'b0,1'b1,4'h4,8'h00,8'h3C}, // R3
    {4'd3, 1'b0,1'b1,4'h1,8'h00,8'h01}, // R3
    {4'd5, 1'b1,1'b0,4'h1,8'h00,8'h00}, // R5 clear
    {4'd5, 1'b1,1'b0,4'h0,8'h00,8'h00}, // R5 arm
    {4'd5, 1'b1,1'b0,4'h5,8'h22,8'h00}, // R5 first
    {4'd5, 1'b1,1'b0,4'h5,8'h33,8'h00}, // R5 second
    {4'd5, 1'b0,1'b1,4'h5,8'h00,8'h22}, // R5
    {4'd5, 1'b0,1'b1,4'h1,8'h00,8'h01}, // R5
    {4'd8, 1'b0,1'b1,4'hF,8'h00,8'h00}  // R8 unmapped
  };

  task automatic op(input logic we, input logic re, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = we; re_i = re; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1;
    we_i = 1'b0; re_i = 1'b0;
  endtask

  task automatic check(input logic [7:0] exp, input int req, input string what);
    n_chk++;
    if (rdata_o !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual 0x%02h expected 0x%02h", req, what, rdata_o, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input int req, input string what);
    op(1'b0, 1'b1, a, 8'h00);
    check(exp, req, what);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][21], VEC[i][20], VEC[i][19:16], VEC[i][15:8]);
      if (VEC[i][20]) check(VEC[i][7:0], int'(VEC[i][25:22]), $sformatf("vector %0d", i));
    end

    // R9: reset while armed and with error set
    op(1'b1, 1'b0, 4'h0, 8'h00);
    #2 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(4'h4, 8'h00, 9, "reg0 after reset");
    rd(4'h5, 8'h0F, 9, "reg1 after reset");
    rd(4'h1, 8'h00, 9, "status after reset");
    op(1'b1, 1'b0, 4'h4, 8'h44);   // R9 arm cleared by reset
    rd(4'h4, 8'h00, 9, "write after reset dropped");
    rd(4'h1, 8'h01, 9, "error after unarmed write");

    // R3: status write cancels the arm
    op(1'b1, 1'b0, 4'h1, 8'h00);
    op(1'b1, 1'b0, 4'h0, 8'h00);
    op(1'b1, 1'b0, 4'h1, 8'h00);
    op(1'b1, 1'b0, 4'h6, 8'h66);
    rd(4'h6, 8'hA5, 3, "status write between");
    rd(4'h1, 8'h01, 3, "error after status write between");

    // R10: writes to reg2 leave reg0/reg1
    op(1'b1, 1'b0, 4'h1, 8'h00);
    op(1'b1, 1'b0, 4'h0, 8'h00);
    op(1'b1, 1'b0, 4'h6, 8'hC3);
    rd(4'h6, 8'hC3, 10, "reg2 target");
    rd(4'h4, 8'h00, 10, "reg0 untouched");
    rd(4'h5, 8'h0F, 10, "reg1 untouched");
    rd(4'h1, 8'h00, 2, "no error on good write");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule